// File: doc/BRIEF.md
# Frame Timestamp Capture and Descriptor Formatting Controller

This block sits beside a MAC's transmit and receive datapaths. When a frame's timestamp point passes, the datapath pulses a start strobe and gives two classification flags: the frame is PTP, and the frame is a PTP event message. On that cycle the block samples the running time-of-day counter, both seconds and nanoseconds. It decides from a per-direction 2-bit mode whether the frame is to be stamped. It then presents two 32-bit timestamp words and a descriptor flag word, ready for the DMA descriptor writer.

Each direction has its own capture channel, and the two channels never interact. A result stays presented, with a ready level, until the descriptor writer acknowledges it. If a new frame arrives while a result is still waiting, the new result replaces the old one and a one-cycle overrun pulse reports the loss. Only the six low bits of seconds are stored; software rebuilds the upper bits from the live counter.

Top module: `ts_capture_ctrl`

## Requirements
- R1: The mode codes are 0 = stamp nothing, 1 = stamp frames flagged both PTP and event, 2 = stamp any frame flagged PTP, 3 = stamp every frame. The block applies the mode of the frame's own direction, sampled on the start-strobe cycle.
- R2: For a stamped frame, word A holds nanoseconds[29:0] in bits 29:0 and seconds[1:0] in bits 31:30.
- R3: For a stamped frame, word B holds seconds[5:2] in bits 3:0 and zero in bits 31:4.
- R4: For a stamped frame, the flag word has exactly one bit set: bit 23 on the transmit channel and bit 2 on the receive channel.
- R5: For a frame the mode does not select, ready is still raised, but the flag word, word A and word B are all zero.
- R6: A start strobe sampled at clock edge k gives ready and the result after edge k. Ready and the result then stay unchanged until an acknowledge is sampled. The acknowledge clears ready, the words and the flags at the next edge.
- R7: An acknowledge while ready is low has no effect. An acknowledge together with a start strobe retires the old result, loads the new one and does not signal overrun.
- R8: A start strobe while ready is high and no acknowledge is present raises overrun for exactly one cycle after that edge, and the new result replaces the old.
- R9: The transmit and receive channels are independent: the inputs of one never change the outputs of the other.
- R10: After synchronous reset, every output is zero.
- R11: Seconds and nanoseconds are sampled on the same clock edge, so the stored pair always comes from one cycle of the time-of-day inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tod_sec | input | SEC_W (48) | Running seconds count |
| tod_ns | input | NS_W (30) | Running nanoseconds count |
| tx_mode | input | 2 | Transmit stamping mode |
| tx_sof | input | 1 | Transmit timestamp-point strobe |
| tx_is_ptp | input | 1 | Transmit frame is PTP |
| tx_is_event | input | 1 | Transmit frame is a PTP event message |
| tx_ack | input | 1 | Transmit result consumed |
| tx_ready | output | 1 | Transmit result waiting |
| tx_word_a | output | 32 | Transmit timestamp word A |
| tx_word_b | output | 32 | Transmit timestamp word B |
| tx_flags | output | 32 | Transmit descriptor flag word |
| tx_overrun | output | 1 | Transmit result overwritten pulse |
| rx_mode | input | 2 | Receive stamping mode |
| rx_sof | input | 1 | Receive timestamp-point strobe |
| rx_is_ptp | input | 1 | Receive frame is PTP |
| rx_is_event | input | 1 | Receive frame is a PTP event message |
| rx_ack | input | 1 | Receive result consumed |
| rx_ready | output | 1 | Receive result waiting |
| rx_word_a | output | 32 | Receive timestamp word A |
| rx_word_b | output | 32 | Receive timestamp word B |
| rx_flags | output | 32 | Receive descriptor flag word |
| rx_overrun | output | 1 | Receive result overwritten pulse |

## Verification
The hardest case to reach is a start strobe that lands in the same cycle as an acknowledge on a pending result, or on a pending result with no acknowledge at all. These are the cases that separate retire-and-reload from overrun. Directed sequences build each of them on purpose. A long random phase then drives strobes and acknowledges at high density on both channels together, with the time-of-day inputs changing every cycle. That way a mismatched seconds/nanoseconds pair, or leakage from one channel into the other, shows up as a word mismatch.

// File: rtl/ts_cap_pkg.sv
package ts_cap_pkg;
  typedef enum logic [1:0] {
    TSM_OFF   = 2'd0,
    TSM_EVENT = 2'd1,
    TSM_PTP   = 2'd2,
    TSM_ALL   = 2'd3
  } ts_mode_e;

  localparam int unsigned WORD_W = 32;
endpackage

// File: rtl/ts_qualify.sv
module ts_qualify
  import ts_cap_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       is_ptp,
  input  logic       is_event,
  output logic       hit
);
  ts_mode_e m;
  assign m = ts_mode_e'(mode);

  always_comb begin
    unique case (m)
      TSM_OFF:   hit = 1'b0;
      TSM_EVENT: hit = is_ptp & is_event;
      TSM_PTP:   hit = is_ptp;
      TSM_ALL:   hit = 1'b1;
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/ts_format.sv
module ts_format
  import ts_cap_pkg::*;
#(
  parameter int unsigned SEC_W    = 48,
  parameter int unsigned NS_W     = 30,
  parameter int unsigned SEC_KEEP = 6
) (
  input  logic [SEC_W-1:0]  sec,
  input  logic [NS_W-1:0]   ns,
  input  logic              en,
  output logic [WORD_W-1:0] word_a,
  output logic [WORD_W-1:0] word_b
);
  localparam int unsigned SEC_A_W = WORD_W - NS_W;
  localparam int unsigned SEC_B_W = SEC_KEEP - SEC_A_W;

  logic [WORD_W-1:0] raw_a, raw_b;
  assign raw_a = {sec[SEC_A_W-1:0], ns};
  assign raw_b = {{(WORD_W-SEC_B_W){1'b0}}, sec[SEC_KEEP-1:SEC_A_W]};

  assign word_a = en ? raw_a : '0;
  assign word_b = en ? raw_b : '0;
endmodule

// File: rtl/ts_channel.sv
module ts_channel
  import ts_cap_pkg::*;
#(
  parameter int unsigned SEC_W    = 48,
  parameter int unsigned NS_W     = 30,
  parameter int unsigned SEC_KEEP = 6,
  parameter int unsigned FLAG_BIT = 23
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEC_W-1:0]  sec,
  input  logic [NS_W-1:0]   ns,
  input  logic [1:0]        mode,
  input  logic              sof,
  input  logic              is_ptp,
  input  logic              is_event,
  input  logic              ack,
  output logic              ready,
  output logic [WORD_W-1:0] word_a,
  output logic [WORD_W-1:0] word_b,
  output logic [WORD_W-1:0] flags,
  output logic              overrun
);
  localparam logic [WORD_W-1:0] FLAG_MASK = WORD_W'(1) << FLAG_BIT;

  logic              hit;
  logic [WORD_W-1:0] fa, fb;

  ts_qualify u_qual (
    .mode     (mode),
    .is_ptp   (is_ptp),
    .is_event (is_event),
    .hit      (hit)
  );

  ts_format #(.SEC_W(SEC_W), .NS_W(NS_W), .SEC_KEEP(SEC_KEEP)) u_fmt (
    .sec    (sec),
    .ns     (ns),
    .en     (hit),
    .word_a (fa),
    .word_b (fb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ready   <= 1'b0;
      word_a  <= '0;
      word_b  <= '0;
      flags   <= '0;
      overrun <= 1'b0;
    end else begin
      overrun <= sof & ready & ~ack;
      if (sof) begin
        ready  <= 1'b1;
        word_a <= fa;
        word_b <= fb;
        flags  <= hit ? FLAG_MASK : '0;
      end else if (ack) begin
        ready  <= 1'b0;
        word_a <= '0;
        word_b <= '0;
        flags  <= '0;
      end
    end
  end
endmodule

// File: rtl/ts_capture_ctrl.sv
module ts_capture_ctrl
  import ts_cap_pkg::*;
#(
  parameter int unsigned SEC_W       = 48,
  parameter int unsigned NS_W        = 30,
  parameter int unsigned SEC_KEEP    = 6,
  parameter int unsigned TX_FLAG_BIT = 23,
  parameter int unsigned RX_FLAG_BIT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEC_W-1:0] tod_sec,
  input  logic [NS_W-1:0]  tod_ns,
  input  logic [1:0]       tx_mode,
  input  logic             tx_sof,
  input  logic             tx_is_ptp,
  input  logic             tx_is_event,
  input  logic             tx_ack,
  output logic             tx_ready,
  output logic [31:0]      tx_word_a,
  output logic [31:0]      tx_word_b,
  output logic [31:0]      tx_flags,
  output logic             tx_overrun,
  input  logic [1:0]       rx_mode,
  input  logic             rx_sof,
  input  logic             rx_is_ptp,
  input  logic             rx_is_event,
  input  logic             rx_ack,
  output logic             rx_ready,
  output logic [31:0]      rx_word_a,
  output logic [31:0]      rx_word_b,
  output logic [31:0]      rx_flags,
  output logic             rx_overrun
);
  localparam int unsigned NCH = 2;

  logic [1:0]        mode_v  [NCH];
  logic              sof_v   [NCH];
  logic              ptp_v   [NCH];
  logic              evt_v   [NCH];
  logic              ack_v   [NCH];
  logic              rdy_v   [NCH];
  logic [WORD_W-1:0] wa_v    [NCH];
  logic [WORD_W-1:0] wb_v    [NCH];
  logic [WORD_W-1:0] flg_v   [NCH];
  logic              ovr_v   [NCH];

  assign mode_v[0] = tx_mode;     assign mode_v[1] = rx_mode;
  assign sof_v[0]  = tx_sof;      assign sof_v[1]  = rx_sof;
  assign ptp_v[0]  = tx_is_ptp;   assign ptp_v[1]  = rx_is_ptp;
  assign evt_v[0]  = tx_is_event; assign evt_v[1]  = rx_is_event;
  assign ack_v[0]  = tx_ack;      assign ack_v[1]  = rx_ack;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int unsigned FB = (c == 0) ? TX_FLAG_BIT : RX_FLAG_BIT;
    ts_channel #(
      .SEC_W(SEC_W), .NS_W(NS_W), .SEC_KEEP(SEC_KEEP), .FLAG_BIT(FB)
    ) u_ch (
      .clk      (clk),
      .rst      (rst),
      .sec      (tod_sec),
      .ns       (tod_ns),
      .mode     (mode_v[c]),
      .sof      (sof_v[c]),
      .is_ptp   (ptp_v[c]),
      .is_event (evt_v[c]),
      .ack      (ack_v[c]),
      .ready    (rdy_v[c]),
      .word_a   (wa_v[c]),
      .word_b   (wb_v[c]),
      .flags    (flg_v[c]),
      .overrun  (ovr_v[c])
    );
  end

  assign tx_ready   = rdy_v[0]; assign rx_ready   = rdy_v[1];
  assign tx_word_a  = wa_v[0];  assign rx_word_a  = wa_v[1];
  assign tx_word_b  = wb_v[0];  assign rx_word_b  = wb_v[1];
  assign tx_flags   = flg_v[0]; assign rx_flags   = flg_v[1];
  assign tx_overrun = ovr_v[0]; assign rx_overrun = ovr_v[1];
endmodule

// File: rtl/ts_cap_chk.sv
module ts_cap_chk #(
  parameter int unsigned SEC_W       = 48,
  parameter int unsigned NS_W        = 30,
  parameter int unsigned SEC_KEEP    = 6,
  parameter int unsigned TX_FLAG_BIT = 23,
  parameter int unsigned RX_FLAG_BIT = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [SEC_W-1:0] tod_sec,
  input logic [NS_W-1:0]  tod_ns,
  input logic [1:0]       tx_mode,
  input logic             tx_sof,
  input logic             tx_is_ptp,
  input logic             tx_is_event,
  input logic             tx_ack,
  input logic             tx_ready,
  input logic [31:0]      tx_word_a,
  input logic [31:0]      tx_word_b,
  input logic [31:0]      tx_flags,
  input logic             tx_overrun,
  input logic [1:0]       rx_mode,
  input logic             rx_sof,
  input logic             rx_is_ptp,
  input logic             rx_is_event,
  input logic             rx_ack,
  input logic             rx_ready,
  input logic [31:0]      rx_word_a,
  input logic [31:0]      rx_word_b,
  input logic [31:0]      rx_flags,
  input logic             rx_overrun
);
  a_r6_sof_gives_ready: assert property (@(posedge clk) disable iff (rst)
    tx_sof |=> tx_ready);
  a_r6_ready_held: assert property (@(posedge clk) disable iff (rst)
    (rx_ready && !rx_ack && !rx_sof) |=> (rx_ready && $stable(rx_word_a) && $stable(rx_flags)));
  a_r6_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (tx_ready && tx_ack && !tx_sof) |=> !tx_ready);
  a_r8_overrun_needs_pending: assert property (@(posedge clk) disable iff (rst)
    tx_overrun |-> $past(tx_ready && tx_sof && !tx_ack));
  a_r8_overrun_rx: assert property (@(posedge clk) disable iff (rst)
    (rx_ready && rx_sof && !rx_ack) |=> rx_overrun);
  a_r4_tx_flag_pos: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tx_flags) && (tx_flags == 32'd0 || tx_flags[TX_FLAG_BIT]));
  a_r4_rx_flag_pos: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rx_flags) && (rx_flags == 32'd0 || rx_flags[RX_FLAG_BIT]));
  a_r5_unstamped_zero: assert property (@(posedge clk) disable iff (rst)
    (tx_flags == 32'd0) |-> (tx_word_a == 32'd0 && tx_word_b == 32'd0));
  a_r1_mode_off: assert property (@(posedge clk) disable iff (rst)
    (rx_sof && rx_mode == 2'd0) |=> (rx_flags == 32'd0));
endmodule

bind ts_capture_ctrl ts_cap_chk #(
  .SEC_W(SEC_W), .NS_W(NS_W), .SEC_KEEP(SEC_KEEP),
  .TX_FLAG_BIT(TX_FLAG_BIT), .RX_FLAG_BIT(RX_FLAG_BIT)
) u_chk (.*);

// File: tb/tb_ts_capture_ctrl.sv
module tb_ts_capture_ctrl;
  localparam int SEC_W = 48;
  localparam int NS_W  = 30;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [SEC_W-1:0] tod_sec = '0;
  logic [NS_W-1:0]  tod_ns  = '0;
  logic [1:0] mode [2];
  logic sof [2], ptp [2], evt [2], ack [2];
  logic rdy [2], ovr [2];
  logic [31:0] wa [2], wb [2], flg [2];

  ts_capture_ctrl dut (
    .clk(clk), .rst(rst), .tod_sec(tod_sec), .tod_ns(tod_ns),
    .tx_mode(mode[0]), .tx_sof(sof[0]), .tx_is_ptp(ptp[0]), .tx_is_event(evt[0]),
    .tx_ack(ack[0]), .tx_ready(rdy[0]), .tx_word_a(wa[0]), .tx_word_b(wb[0]),
    .tx_flags(flg[0]), .tx_overrun(ovr[0]),
    .rx_mode(mode[1]), .rx_sof(sof[1]), .rx_is_ptp(ptp[1]), .rx_is_event(evt[1]),
    .rx_ack(ack[1]), .rx_ready(rdy[1]), .rx_word_a(wa[1]), .rx_word_b(wb[1]),
    .rx_flags(flg[1]), .rx_overrun(ovr[1])
  );

  int checks = 0;
  int failures = 0;

  logic m_rdy [2], m_ov [2];
  logic [31:0] m_a [2], m_b [2], m_f [2];

  function automatic logic selects(logic [1:0] md, logic p, logic e);
    case (md)
      2'd0: return 1'b0;
      2'd1: return p & e;
      2'd2: return p;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [31:0] flag_of(int ch);
    return (ch == 0) ? 32'h0080_0000 : 32'h0000_0004;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_edge();
    for (int c = 0; c < 2; c++) begin
      if (rst) begin
        m_rdy[c] = 0; m_ov[c] = 0; m_a[c] = 0; m_b[c] = 0; m_f[c] = 0;
      end else begin
        m_ov[c] = sof[c] & m_rdy[c] & ~ack[c];
        if (sof[c]) begin
          logic h;
          h = selects(mode[c], ptp[c], evt[c]);
          m_rdy[c] = 1;
          m_a[c] = h ? {tod_sec[1:0], tod_ns} : 32'd0;
          m_b[c] = h ? {28'd0, tod_sec[5:2]} : 32'd0;
          m_f[c] = h ? flag_of(c) : 32'd0;
        end else if (ack[c]) begin
          m_rdy[c] = 0; m_a[c] = 0; m_b[c] = 0; m_f[c] = 0;
        end
      end
    end
  endtask

  task automatic compare(string req);
    for (int c = 0; c < 2; c++) begin
      chk(req, (c == 0) ? "tx_ready" : "rx_ready", 32'(rdy[c]), 32'(m_rdy[c]));
      chk(req, (c == 0) ? "tx_word_a" : "rx_word_a", wa[c], m_a[c]);
      chk(req, (c == 0) ? "tx_word_b" : "rx_word_b", wb[c], m_b[c]);
      chk(req, (c == 0) ? "tx_flags" : "rx_flags", flg[c], m_f[c]);
      chk(req, (c == 0) ? "tx_overrun" : "rx_overrun", 32'(ovr[c]), 32'(m_ov[c]));
    end
  endtask

  task automatic cycle(string req);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(req);
  endtask

  task automatic idle_inputs();
    for (int c = 0; c < 2; c++) begin
      sof[c] = 0; ack[c] = 0; ptp[c] = 0; evt[c] = 0;
    end
  endtask

  task automatic new_tod();
    tod_sec = {$urandom(), $urandom()} & {SEC_W{1'b1}};
    tod_ns  = NS_W'($urandom() % 1000000000);
  endtask

  task automatic frame(int c, logic [1:0] md, logic p, logic e, string req);
    idle_inputs();
    mode[c] = md; sof[c] = 1; ptp[c] = p; evt[c] = e; ack[c] = 1;
    new_tod();
    cycle(req);
    idle_inputs();
    chk(req, "stamped", 32'(flg[c] != 0), 32'(selects(md, p, e)));
    ack[c] = 1;
    cycle(req);
    ack[c] = 0;
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    mode[0] = 2'd3; mode[1] = 2'd3;
    idle_inputs();
    rst = 1;
    cycle("R10");
    cycle("R10");
    chk("R10", "tx_ready after reset", 32'(rdy[0]), 32'd0);
    chk("R10", "rx_flags after reset", flg[1], 32'd0);
    @(negedge clk); rst = 0;

    // R2/R3/R4: known value on transmit
    tod_sec = 48'h0000_0000_0007; tod_ns = 30'h0123_4567;
    mode[0] = 2'd3; sof[0] = 1;
    cycle("R2");
    chk("R2", "tx word_a known", wa[0], 32'hC123_4567);
    chk("R3", "tx word_b known", wb[0], 32'h0000_0001);
    chk("R4", "tx flag bit23", flg[0], 32'h0080_0000);
    chk("R9", "rx untouched", 32'(rdy[1]), 32'd0);
    sof[0] = 0;
    // R6: held without ack while tod changes
    new_tod();
    cycle("R6");
    cycle("R6");
    chk("R11", "held pair unchanged", wa[0], 32'hC123_4567);
    ack[0] = 1;
    cycle("R6");
    chk("R6", "ack clears", 32'(rdy[0]), 32'd0);
    // R7: ack idle ignored
    cycle("R7");
    ack[0] = 0;

    // R4 receive flag bit 2, sec top bits
    tod_sec = 48'h1234_5678_9ABF; tod_ns = 30'h3FFF_FFFF;
    mode[1] = 2'd2; sof[1] = 1; ptp[1] = 1;
    cycle("R4");
    chk("R4", "rx flag bit2", flg[1], 32'h0000_0004);
    chk("R3", "rx word_b", wb[1], 32'h0000_000F);
    chk("R2", "rx word_a", wa[1], 32'hFFFF_FFFF);
    // R8 overrun: sof while pending, no ack, unselected frame
    mode[1] = 2'd0; new_tod();
    cycle("R8");
    chk("R8", "rx overrun pulse", 32'(ovr[1]), 32'd1);
    chk("R5", "replaced unstamped", flg[1] | wa[1] | wb[1], 32'd0);
    chk("R5", "ready on unstamped", 32'(rdy[1]), 32'd1);
    // R7: sof plus ack, no overrun
    mode[1] = 2'd3; ack[1] = 1; new_tod();
    cycle("R7");
    chk("R7", "no overrun with ack", 32'(ovr[1]), 32'd0);
    sof[1] = 0;
    cycle("R8");
    chk("R8", "overrun one cycle", 32'(ovr[1]), 32'd0);
    idle_inputs();

    // R1: every mode against every class on both channels
    for (int c = 0; c < 2; c++)
      for (int md = 0; md < 4; md++)
        for (int k = 0; k < 4; k++)
          frame(c, 2'(md), k[1], k[0], "R1");

    // Random phase
    for (int i = 0; i < 3000; i++) begin
      for (int c = 0; c < 2; c++) begin
        mode[c] = 2'($urandom());
        sof[c]  = ($urandom() % 3) == 0;
        ptp[c]  = $urandom();
        evt[c]  = $urandom();
        ack[c]  = ($urandom() % 2) == 0;
      end
      new_tod();
      cycle("R9");
    end
    idle_inputs();

    // R10: reset mid-activity
    sof[0] = 1; sof[1] = 1; mode[0] = 3; mode[1] = 3;
    cycle("R6");
    idle_inputs();
    rst = 1;
    cycle("R10");
    chk("R10", "reset clears tx", 32'(rdy[0]) | wa[0] | flg[0], 32'd0);
    rst = 0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule